// File: doc/BRIEF.md
# Pulse Width and Period Capture Unit

This block times a digital input waveform against the system clock. The pin is brought into the clock domain through a flop synchroniser, its rising and falling transitions are detected, and a saturating counter accumulates tick-enabled cycles between a start transition and a capture transition. When the capture transition arrives, the count is latched into a data register that software reads through a simple read port.

A two-bit measurement selector picks one of four measurements: low pulse width, high pulse width, period between falling transitions, or period between rising transitions. A small control state machine has two states. `ST_SEEK` waits for the start transition; the transition `SEEK->COUNT` fires on it and zeroes the counter. `ST_COUNT` accumulates ticks; on the capture transition it latches the count. It then either stays in `ST_COUNT` with the counter zeroed again (period modes, transition `COUNT->COUNT`) or returns through `COUNT->SEEK` (pulse modes). Any change of the selector forces `COUNT->SEEK` or holds `ST_SEEK`, so a capture without a valid start is never reported. A one-cycle interrupt request can accompany each latch. An optional read side effect zeroes the data register after a CPU read, but reads marked as debugger accesses never do.

Top module: `pulse_cap`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `irq_o` is 0.
- R2: Mode 01 measures a high pulse. The count starts at a rising transition and is latched at the next falling transition. With the tick enable held high, a pin held high for N clocks yields N.
- R3: Mode 00 measures a low pulse. The count starts at a falling transition and is latched at the next rising transition, giving N for a low level held for N clocks.
- R4: Mode 10 latches the number of clocks between two consecutive falling transitions.
- R5: Mode 11 latches the number of clocks between two consecutive rising transitions.
- R6: The counter advances only in cycles where `tick_en_i` is high. The latched value equals the number of tick-enabled cycles from the cycle after the start edge up to and including the capture-edge cycle.
- R7: The counter saturates at 2^CNT_W-1 and never wraps.
- R8: A capture transition seen without a prior start transition since reset or the last mode change latches nothing and raises no interrupt.
- R9: With `irq_en_i` high, `irq_o` is high for exactly one cycle, in the cycle after the data register takes a new capture. With `irq_en_i` low, `irq_o` stays low.
- R10: A read (`rd_en_i`=1, `rd_dbg_i`=0) returns the current value on `rd_data_o`. If `autoclr_en_i` is high, the register reads 0 from the next cycle. If it is low, the register is unchanged.
- R11: A read with `rd_dbg_i`=1 never clears the data register.
- R12: When a capture and a clearing read fall in the same cycle, the register takes the new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous waveform input |
| tick_en_i | input | 1 | Counter advance qualifier |
| mode_i | input | 2 | Measurement select: 00 low pulse, 01 high pulse, 10 fall-to-fall period, 11 rise-to-rise period |
| irq_en_i | input | 1 | Enables the capture interrupt pulse |
| autoclr_en_i | input | 1 | Enables clear-after-read of the data register |
| rd_en_i | input | 1 | Read strobe for the data register |
| rd_dbg_i | input | 1 | Marks the read as a debugger access |
| rd_data_o | output | CNT_W | Current captured value |
| irq_o | output | 1 | One-cycle capture interrupt request |

## Verification
A new capture and a clearing CPU read can land on the same clock edge, because the register is written from two independent sources. The bench provokes this by timing a high pulse so that the read strobe sits exactly on the edge where the synchronised falling transition is acted on, three clocks after the pin falls. It then requires the freshly measured width to be visible afterwards rather than zero. Separate scenarios show that the clear does act when no capture competes, and that a debugger read leaves the value alone.

// File: rtl/pcap_pkg.sv
`timescale 1ns/1ps
package pcap_pkg;
    typedef enum logic [1:0] {
        MODE_LOW_PULSE  = 2'b00,
        MODE_HIGH_PULSE = 2'b01,
        MODE_PER_FALL   = 2'b10,
        MODE_PER_RISE   = 2'b11
    } meas_mode_e;

    typedef enum logic {
        ST_SEEK  = 1'b0,
        ST_COUNT = 1'b1
    } cap_state_e;
endpackage

// File: rtl/pcap_sync.sv
`timescale 1ns/1ps
module pcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o =  chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/pcap_counter.sv
`timescale 1ns/1ps
module pcap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] sat_inc;

    always_comb begin
        sat_inc    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        cnt_next_o = (run_i && tick_i) ? sat_inc : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else                cnt_q <= cnt_next_o;
    end
endmodule

// File: rtl/pcap_ctrl.sv
`timescale 1ns/1ps
module pcap_ctrl
    import pcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic [1:0] mode_i,
    output logic       run_o,
    output logic       restart_o,
    output logic       capture_o
);
    cap_state_e state_q, state_d;
    meas_mode_e mode_q;
    meas_mode_e mode_cur;
    logic       mode_chg;
    logic       start_edge, cap_edge, is_period;

    assign mode_cur  = meas_mode_e'(mode_i);
    assign mode_chg  = (mode_cur != mode_q);
    assign is_period = mode_i[1];

    always_comb begin
        unique case (mode_cur)
            MODE_LOW_PULSE:  begin start_edge = fall_i; cap_edge = rise_i; end
            MODE_HIGH_PULSE: begin start_edge = rise_i; cap_edge = fall_i; end
            MODE_PER_FALL:   begin start_edge = fall_i; cap_edge = fall_i; end
            MODE_PER_RISE:   begin start_edge = rise_i; cap_edge = rise_i; end
            default:         begin start_edge = 1'b0;   cap_edge = 1'b0;   end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: begin
                if (!mode_chg && start_edge) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (mode_chg)                   state_d = ST_SEEK;
                else if (cap_edge && !is_period) state_d = ST_SEEK;
            end
            default: state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
            mode_q  <= MODE_LOW_PULSE;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_cur;
        end
    end

    always_comb begin
        run_o     = 1'b0;
        restart_o = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                restart_o = start_edge && !mode_chg;
            end
            ST_COUNT: begin
                run_o     = 1'b1;
                capture_o = cap_edge && !mode_chg;
                restart_o = cap_edge && !mode_chg && is_period;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcap_dreg.sv
`timescale 1ns/1ps
module pcap_dreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [CNT_W-1:0] cap_val_i,
    input  logic             irq_en_i,
    input  logic             autoclr_en_i,
    input  logic             rd_en_i,
    input  logic             rd_dbg_i,
    output logic [CNT_W-1:0] data_q,
    output logic             irq_q
);
    logic clr_req;

    assign clr_req = rd_en_i && !rd_dbg_i && autoclr_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= capture_i && irq_en_i;
            if (capture_i)    data_q <= cap_val_i;
            else if (clr_req) data_q <= '0;
        end
    end
endmodule

// File: rtl/pulse_cap.sv
`timescale 1ns/1ps
module pulse_cap #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             tick_en_i,
    input  logic [1:0]       mode_i,
    input  logic             irq_en_i,
    input  logic             autoclr_en_i,
    input  logic             rd_en_i,
    input  logic             rd_dbg_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             irq_o
);
    logic             rise, fall;
    logic             run, restart, cap_fire;
    logic [CNT_W-1:0] cnt_q, cnt_next;

    pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .rise_o(rise), .fall_o(fall)
    );

    pcap_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .mode_i(mode_i), .run_o(run), .restart_o(restart), .capture_o(cap_fire)
    );

    pcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .run_i(run),
        .tick_i(tick_en_i), .cnt_q(cnt_q), .cnt_next_o(cnt_next)
    );

    pcap_dreg #(.CNT_W(CNT_W)) u_dreg (
        .clk(clk), .rst_n(rst_n), .capture_i(cap_fire), .cap_val_i(cnt_next),
        .irq_en_i(irq_en_i), .autoclr_en_i(autoclr_en_i), .rd_en_i(rd_en_i),
        .rd_dbg_i(rd_dbg_i), .data_q(rd_data_o), .irq_q(irq_o)
    );
endmodule

// File: rtl/pcap_checker.sv
`timescale 1ns/1ps
module pcap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en_i,
    input logic             irq_en_i,
    input logic             autoclr_en_i,
    input logic             rd_en_i,
    input logic             rd_dbg_i,
    input logic [CNT_W-1:0] rd_data_o,
    input logic             irq_o,
    input logic             cap_fire,
    input logic             run,
    input logic             restart,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cap_fire) && $past(irq_en_i)));

    p_autoclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_dbg_i && autoclr_en_i && !cap_fire) |=> (rd_data_o == '0));

    p_dbg_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_dbg_i && !cap_fire) |=> $stable(rd_data_o));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_fire && !(rd_en_i && !rd_dbg_i && autoclr_en_i)) |=> $stable(rd_data_o));

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en_i && !restart && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    p_tick_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_i && !restart) |=> $stable(cnt_q));
endmodule

bind pulse_cap pcap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .irq_en_i(irq_en_i),
    .autoclr_en_i(autoclr_en_i), .rd_en_i(rd_en_i), .rd_dbg_i(rd_dbg_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .cap_fire(cap_fire), .run(run),
    .restart(restart), .cnt_q(cnt_q)
);

// File: tb/tb_pulse_cap.sv
`timescale 1ns/1ps
module tb_pulse_cap;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin = 1'b0, tick = 1'b1, irq_en = 1'b1, autoclr = 1'b0;
    logic          rd_en = 1'b0, rd_dbg = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] rd_data;
    logic          irq;
    int            n_chk = 0, n_err = 0, irq_cnt = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    pulse_cap #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .tick_en_i(tick), .mode_i(mode),
        .irq_en_i(irq_en), .autoclr_en_i(autoclr), .rd_en_i(rd_en),
        .rd_dbg_i(rd_dbg), .rd_data_o(rd_data), .irq_o(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m, input logic idle);
        pin = idle; mode = m; step(6);
    endtask

    task automatic t_reset;
        chk("R1 data", rd_data, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_high_pulse;
        int base;
        set_mode(2'b01, 1'b0);
        base = irq_cnt;
        pin = 1'b1; step(10);
        pin = 1'b0; step(2);
        chk("R9 irq not early", irq, 0);
        step(1);
        chk("R9 irq pulse", irq, 1);
        chk("R2 high width", rd_data, 10);
        step(1);
        chk("R9 irq one cycle", irq, 0);
        step(3);
        chk("R9 irq count", irq_cnt - base, 1);
    endtask

    task automatic t_low_pulse;
        set_mode(2'b00, 1'b1);
        pin = 1'b0; step(7);
        pin = 1'b1; step(5);
        chk("R3 low width", rd_data, 7);
    endtask

    task automatic t_per_fall;
        int base;
        set_mode(2'b10, 1'b1);
        base = irq_cnt;
        pin = 1'b0; step(4);
        pin = 1'b1; step(5);
        pin = 1'b0; step(6);
        chk("R4 fall period", rd_data, 9);
        chk("R8 first fall discarded", irq_cnt - base, 1);
    endtask

    task automatic t_per_rise;
        int base;
        irq_en = 1'b0;
        set_mode(2'b11, 1'b0);
        base = irq_cnt;
        pin = 1'b1; step(3);
        pin = 1'b0; step(8);
        pin = 1'b1; step(6);
        chk("R5 rise period", rd_data, 11);
        chk("R9 irq disabled", irq_cnt - base, 0);
        irq_en = 1'b1;
    endtask

    task automatic t_tick;
        set_mode(2'b01, 1'b0);
        for (int i = 0; i < 16; i++) begin
            tick = (i % 2 == 0);
            pin  = (i < 10);
            step(1);
        end
        tick = 1'b1;
        chk("R6 tick gated width", rd_data, 5);
    endtask

    task automatic t_discard;
        int base;
        set_mode(2'b00, 1'b1);
        set_mode(2'b01, 1'b1);
        base = irq_cnt;
        pin = 1'b0; step(6);
        chk("R8 data kept", rd_data, 5);
        chk("R8 no irq", irq_cnt - base, 0);
    endtask

    task automatic t_saturate;
        pin = 1'b1; step(300);
        pin = 1'b0; step(6);
        chk("R7 saturated", rd_data, 255);
    endtask

    task automatic t_autoclr;
        autoclr = 1'b0; rd_en = 1'b1; step(1); rd_en = 1'b0; step(1);
        chk("R10 no clear when disabled", rd_data, 255);
        autoclr = 1'b1; rd_en = 1'b1;
        chk("R10 read value", rd_data, 255);
        step(1); rd_en = 1'b0;
        chk("R10 cleared", rd_data, 0);
        autoclr = 1'b0;
    endtask

    task automatic t_debug;
        pin = 1'b1; step(4);
        pin = 1'b0; step(6);
        chk("R11 setup", rd_data, 4);
        autoclr = 1'b1; rd_en = 1'b1; rd_dbg = 1'b1; step(1);
        rd_en = 1'b0; rd_dbg = 1'b0; step(1);
        chk("R11 debug read kept", rd_data, 4);
        autoclr = 1'b0;
    endtask

    task automatic t_race;
        pin = 1'b1; step(6);
        pin = 1'b0; step(2);
        autoclr = 1'b1; rd_en = 1'b1; step(1);
        rd_en = 1'b0;
        chk("R12 capture wins", rd_data, 6);
        step(1);
        chk("R12 capture persists", rd_data, 6);
        autoclr = 1'b0;
    endtask

    initial begin
        step(3);
        t_reset;
        rst_n = 1'b1;
        step(2);
        t_reset;
        t_high_pulse;
        t_low_pulse;
        t_per_fall;
        t_per_rise;
        t_tick;
        t_discard;
        t_saturate;
        t_autoclr;
        t_debug;
        t_race;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule